// File: doc/BRIEF.md
# Programmable AND-OR Array

This block emulates a small fixed-OR programmable logic device. Ten primary inputs and six fed-back outputs form a sixteen-signal array. Each signal offers a true literal and a complement literal to every product term. Each of the eight outputs owns eight product terms. One term gates the output's drive enable. The other seven are ORed, and the result is inverted onto the output. The outputs are combinational functions of the inputs and the stored fuse map.

The fuse map is loaded one product term per clock through a write port. Each term is a 32-bit word. Bit 2i selects the true literal of array signal i, and bit 2i+1 selects its complement. Array signals 0 to 9 are the primary inputs. Array signals 10 to 15 are the values of outputs 0 to 5. A disabled output drives its value low and feeds back 0. Feedback chains that do not loop settle within the same cycle.

Top module: `pal_array_top`

## Requirements
- R1: Fuse bit 2i of a term word selects the true literal and bit 2i+1 selects the complement literal of array signal i. Signals 0 to 9 are `in_pins[9:0]`, and signals 10 to 15 are `out_val[0]` to `out_val[5]`.
- R2: When `cfg_we` is high at a rising edge, `cfg_data` is stored as term `cfg_addr`. The address is output*8+slot, where slot 0 is the enable term and slots 1 to 7 are the sum terms. The outputs reflect the new term after that edge. Terms not addressed keep their contents.
- R3: A term with no fuse bit set evaluates to 1.
- R4: A term that selects both literals of the same signal evaluates to 0.
- R5: An enabled output drives the inverse of the OR of its seven sum terms.
- R6: When an output's enable term is 0, `out_en` for that output is 0, `out_val` for that output is 0, and its feedback signal reads 0.
- R7: Synchronous active-high reset clears every fuse, which leaves every output enabled and low.
- R8: An output may use the values of outputs 0 to 5 as literals. A feedback chain without a loop gives its final value in the same cycle.
- R9: The terms of one output never influence another output, except through feedback.
- R10: The outputs follow `in_pins` combinationally. While no write occurs and the inputs are stable, the outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse write port |
| rst | input | 1 | Synchronous active-high reset; clears the fuse map |
| cfg_we | input | 1 | Term write strobe |
| cfg_addr | input | 6 | Term index: output*8 + slot |
| cfg_data | input | 32 | Term fuse word, two bits per array signal |
| in_pins | input | 10 | Primary array inputs |
| out_val | output | 8 | Output values, inverted sum of products, 0 when disabled |
| out_en | output | 8 | Output drive enables; 0 means high impedance |

## Verification
A term write and an input change can occur in the same cycle. In that cycle the outputs must still reflect the old term for the new inputs, and they switch to the new term only after the edge. The bench provokes this collision by randomising writes and input values together on most cycles. A behavioural model updates its own map only at the edge and relaxes feedback until the outputs are stable. Every cycle is compared against that model. Directed cases also disable an output that another output depends on, and confirm that the dependent output sees a 0.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int unsigned PRIM_COUNT = 10;
    localparam int unsigned OUT_COUNT  = 8;
    localparam int unsigned SUM_COUNT  = 7;
    localparam int unsigned FB_COUNT   = 6;

    // Slot 0 of every output group holds the drive-enable term.
    localparam int unsigned ENABLE_SLOT = 0;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic int unsigned fuse_bit(input int unsigned sig, input logic comp);
        return 2 * sig + (comp ? 1 : 0);
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
    parameter int unsigned N_TERM = 64,
    parameter int unsigned FUSE_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [FUSE_W-1:0]             data,
    output logic [N_TERM-1:0][FUSE_W-1:0] fuse_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fuse_q <= '0;
        end else if (we) begin
            fuse_q[addr] <= data;
        end
    end

    // R2: a written word is present one edge later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> fuse_q[$past(addr)] == $past(data));

    // R2: without a write the map does not move
    a_r2_map_holds: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(fuse_q));

endmodule

// File: rtl/pal_term_array.sv
module pal_term_array #(
    parameter int unsigned N_TERM = 64,
    parameter int unsigned N_ARR  = 16,
    localparam int unsigned FUSE_W = 2 * N_ARR
) (
    input  logic [N_TERM-1:0][FUSE_W-1:0] fuse_q,
    input  logic [N_ARR-1:0]              arr,
    output logic [N_TERM-1:0]             term_v
);
    import pal_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_ARR-1:0] kill;
        always_comb begin
            for (int i = 0; i < N_ARR; i++) begin
                // a selected true literal on a low signal, or a selected
                // complement literal on a high signal, forces the term to 0
                kill[i] = (fuse_q[t][fuse_bit(i, 1'b0)] & ~arr[i])
                        | (fuse_q[t][fuse_bit(i, 1'b1)] &  arr[i]);
            end
            term_v[t] = ~|kill;
        end
    end

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
    parameter int unsigned SLOTS = 8
) (
    input  logic [SLOTS-1:0] terms,
    output pal_pkg::pin_t    pin
);
    import pal_pkg::*;

    logic any_sum;

    always_comb begin
        any_sum   = |terms[SLOTS-1:ENABLE_SLOT+1];
        pin.drive = terms[ENABLE_SLOT];
        pin.level = terms[ENABLE_SLOT] & ~any_sum;
    end

endmodule

// File: rtl/pal_plane.sv
module pal_plane #(
    parameter int unsigned N_PRIM = 10,
    parameter int unsigned N_OUT  = 8,
    parameter int unsigned N_SUM  = 7,
    parameter int unsigned N_FB   = 6,
    localparam int unsigned N_ARR  = N_PRIM + N_FB,
    localparam int unsigned FUSE_W = 2 * N_ARR,
    localparam int unsigned SLOTS  = N_SUM + 1,
    localparam int unsigned N_TERM = N_OUT * SLOTS
) (
    input  logic [N_TERM-1:0][FUSE_W-1:0] fuse_q,
    input  logic [N_PRIM-1:0]             prim,
    input  logic [N_FB-1:0]               fb_in,
    output logic [N_OUT-1:0]              val,
    output logic [N_OUT-1:0]              en
);
    import pal_pkg::*;

    logic [N_TERM-1:0] term_v;

    pal_term_array #(.N_TERM(N_TERM), .N_ARR(N_ARR)) u_terms (
        .fuse_q (fuse_q),
        .arr    ({fb_in, prim}),
        .term_v (term_v)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        pin_t pin;
        pal_out_cell #(.SLOTS(SLOTS)) u_cell (
            .terms (term_v[o*SLOTS +: SLOTS]),
            .pin   (pin)
        );
        assign val[o] = pin.level;
        assign en[o]  = pin.drive;
    end

endmodule

// File: rtl/pal_array_top.sv
module pal_array_top #(
    parameter int unsigned N_PRIM = pal_pkg::PRIM_COUNT,
    parameter int unsigned N_OUT  = pal_pkg::OUT_COUNT,
    parameter int unsigned N_SUM  = pal_pkg::SUM_COUNT,
    parameter int unsigned N_FB   = pal_pkg::FB_COUNT,
    localparam int unsigned N_ARR  = N_PRIM + N_FB,
    localparam int unsigned FUSE_W = 2 * N_ARR,
    localparam int unsigned SLOTS  = N_SUM + 1,
    localparam int unsigned N_TERM = N_OUT * SLOTS,
    localparam int unsigned ADDR_W = $clog2(N_TERM),
    localparam int unsigned PASSES = N_FB + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FUSE_W-1:0] cfg_data,
    input  logic [N_PRIM-1:0] in_pins,
    output logic [N_OUT-1:0]  out_val,
    output logic [N_OUT-1:0]  out_en
);

    logic [N_TERM-1:0][FUSE_W-1:0] fuse_q;

    pal_fuse_store #(.N_TERM(N_TERM), .FUSE_W(FUSE_W), .ADDR_W(ADDR_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .data   (cfg_data),
        .fuse_q (fuse_q)
    );

    // Feedback is unrolled into a chain of array copies: pass 0 sees all
    // feedback at 0, each later pass sees the previous pass's outputs.
    logic [N_OUT-1:0] val_s [PASSES];
    logic [N_OUT-1:0] en_s  [PASSES];

    for (genvar p = 0; p < PASSES; p++) begin : g_pass
        logic [N_FB-1:0] fb;
        if (p == 0) begin : g_first
            assign fb = '0;
        end else begin : g_next
            assign fb = val_s[p-1][N_FB-1:0];
        end
        pal_plane #(.N_PRIM(N_PRIM), .N_OUT(N_OUT), .N_SUM(N_SUM), .N_FB(N_FB)) u_plane (
            .fuse_q (fuse_q),
            .prim   (in_pins),
            .fb_in  (fb),
            .val    (val_s[p]),
            .en     (en_s[p])
        );
    end

    assign out_val = val_s[PASSES-1];
    assign out_en  = en_s[PASSES-1];

    // R7: the first cycle out of reset shows a blank map
    a_r7_blank_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_en == '1 && out_val == '0));

    // R10: no write and steady inputs give steady outputs
    a_r10_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_we) && !$past(rst) && $stable(in_pins))
            |-> ($stable(out_val) && $stable(out_en)));

endmodule

// File: tb/test_pal_array_top.sv
module test_pal_array_top;

    localparam int NP = 10;
    localparam int NO = 8;
    localparam int NF = 6;
    localparam int NT = 64;
    localparam logic [31:0] ZERO_T = 32'h3;   // both literals of signal 0

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic [9:0]  in_pins = '0;
    logic [7:0]  out_val;
    logic [7:0]  out_en;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [NT];

    always #10 clk = ~clk;

    pal_array_top i_pal_array_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_pins(in_pins), .out_val(out_val), .out_en(out_en)
    );

    function automatic logic term_eval(input logic [31:0] w, input logic [15:0] a);
        logic r = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (w[2*i] && !a[i]) r = 1'b0;
            if (w[2*i+1] && a[i]) r = 1'b0;
        end
        return r;
    endfunction

    // relax feedback until nothing changes
    task automatic model_eval(input logic [9:0] pi, output logic [7:0] v, output logic [7:0] e);
        logic [7:0] nv;
        logic [7:0] ne;
        logic any;
        v = '0; e = '0;
        for (int it = 0; it < 20; it++) begin
            for (int o = 0; o < NO; o++) begin
                ne[o] = term_eval(mdl[o*8], {v[NF-1:0], pi});
                any = 1'b0;
                for (int s = 1; s < 8; s++) any = any | term_eval(mdl[o*8+s], {v[NF-1:0], pi});
                nv[o] = ne[o] & ~any;
            end
            v = nv; e = ne;
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare mid-cycle, update model at edge
    task automatic cycle(input logic r, input logic we, input logic [5:0] a,
                         input logic [31:0] d, input logic [9:0] p, input string tag);
        logic [7:0] ev;
        logic [7:0] ee;
        @(negedge clk);
        rst = r; cfg_we = we; cfg_addr = a; cfg_data = d; in_pins = p;
        #5;
        if (!r) begin
            model_eval(p, ev, ee);
            chk(tag, {out_en, out_val}, {ee, ev});
        end
        @(posedge clk);
        if (r) begin
            for (int t = 0; t < NT; t++) mdl[t] = '0;
        end else if (we) begin
            mdl[a] = d;
        end
        #2;
    endtask

    task automatic prog_out(input int o, input logic [31:0] enw, input logic [31:0] t1,
                            input logic [9:0] p);
        cycle(0, 1, 6'(o*8), enw, p, "R2 write");
        cycle(0, 1, 6'(o*8+1), t1, p, "R2 write");
        for (int s = 2; s < 8; s++) cycle(0, 1, 6'(o*8+s), ZERO_T, p, "R2 write");
    endtask

    function automatic logic [31:0] rnd_term(input int o);
        logic [31:0] w = '0;
        int n = $urandom_range(0, 3);
        int lim = NP + ((o < NF) ? o : NF);
        for (int k = 0; k < n; k++) begin
            int idx = $urandom_range(0, lim - 1);
            w[2*idx + $urandom_range(0, 1)] = 1'b1;
        end
        return w;
    endfunction

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog all-R actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) mdl[t] = '0;
        cycle(1, 0, 0, 0, 10'h000, "reset");
        cycle(1, 1, 6'd5, 32'hFFFF_FFFF, 10'h3FF, "reset");
        // R7: blank map after reset, write during reset ignored
        cycle(0, 0, 0, 0, 10'h155, "R7 blank");
        chk("R7 outputs after reset", {out_en, out_val}, {8'hFF, 8'h00});
        chk("R3 empty terms give low enabled outputs", {out_en, out_val}, {8'hFF, 8'h00});

        // R1/R5: output 0 = NOT in0
        prog_out(0, 32'h0, 32'h1, 10'h000);
        cycle(0, 0, 0, 0, 10'h000, "R5 invert");
        chk("R5 out0 with in0=0", 16'(out_val[0]), 16'h1);
        chk("R9 other outputs untouched", 16'(out_val[7:1]), 16'h0);
        cycle(0, 0, 0, 0, 10'h001, "R5 invert");
        chk("R1 out0 with in0=1", 16'(out_val[0]), 16'h0);

        // R8: output 1 = NOT in1, output 2 = NOT out1 via feedback signal 11
        prog_out(1, 32'h0, 32'h4, 10'h000);
        prog_out(2, 32'h0, 32'h1 << 22, 10'h000);
        cycle(0, 0, 0, 0, 10'h000, "R8 chain");
        chk("R8 in1=0 out1,out2", 16'(out_val[2:1]), 16'h1);
        cycle(0, 0, 0, 0, 10'h002, "R8 chain");
        chk("R8 in1=1 out1,out2", 16'(out_val[2:1]), 16'h2);

        // R10: inputs change with no clock edge
        @(negedge clk); in_pins = 10'h000; #3;
        chk("R10 comb response", 16'(out_val[2:1]), 16'h1);

        // R6: disable output 1; its feedback reads 0, so out2 = 1
        cycle(0, 1, 6'd8, ZERO_T, 10'h002, "R6 disable");
        cycle(0, 0, 0, 0, 10'h002, "R6 disable");
        chk("R6 out1 enable,value", {15'h0, out_en[1]}, 16'h0);
        chk("R6 out1 value low", 16'(out_val[1]), 16'h0);
        chk("R6 feedback reads 0", 16'(out_val[2]), 16'h1);

        // R4: output 4 has every sum term zeroed
        prog_out(4, 32'h0, ZERO_T, 10'h3FF);
        cycle(0, 0, 0, 0, 10'h3FF, "R4 both literals");
        chk("R4 all sums zero drives 1", 16'(out_val[4]), 16'h1);
        chk("R3 untouched out3", {15'h0, out_val[3]}, 16'h0);

        // random writes colliding with random inputs
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] a = 6'($urandom_range(0, NT - 1));
            logic [31:0] d;
            if (a[2:0] == 3'd0) d = ($urandom_range(0, 3) == 0) ? rnd_term(a / 8) : 32'h0;
            else d = rnd_term(a / 8);
            cycle(0, ($urandom_range(0, 1) == 1), a, d, 10'($urandom), "R2+R8 random");
            if (n == 1500) begin
                cycle(1, 0, 0, 0, 10'h0, "reset");
                cycle(0, 0, 0, 0, 10'h2AA, "R7 mid reset");
                chk("R7 mid-run reset", {out_en, out_val}, {8'hFF, 8'h00});
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule